// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block sits behind the command decoder of a synchronous DRAM model or controller. When a read or write column command arrives, it produces the column for every data beat of the burst. It supports lengths of 1, 2, 4 and 8, as well as a full row. It can walk the columns in either linear or XOR-interleaved order. Linear and interleaved bursts wrap inside a window aligned to the burst length. A full-row burst runs on until something ends it.

The block also times the data side. Each read beat becomes a read-valid flag either two or three clocks later. The data mask acts on two clocks: for a read it disables the output enable two clocks after it is seen, and for a write it blocks the beat on the same clock. A burst ends early on a stop strobe. A new read or write restarts a full burst from the new column on any clock.

Top module: `sdr_colseq`

## Requirements
- R1: With `cfg_ilv`=0, beat k of a length-L burst (L in 2, 4, 8) addresses column `{start[upper], (start[low]+k) mod L}`, where the low field is log2(L) bits wide. A start of 10 at L=4 gives 10, 11, 8, 9.
- R2: With `cfg_ilv`=1, beat k of a length-L burst uses low bits `start[low] XOR k` and keeps the upper bits. A start of 0x12 at L=8 gives 0x12, 0x13, 0x10, 0x11, 0x16, 0x17, 0x14, 0x15.
- R3: `cfg_len` encodes the burst length: 0 means 1 beat, 1 means 2, 2 means 4, 3 means 8 and 7 means a full row; 4 to 6 act as 1. `beat_act` is high for exactly L consecutive cycles, beginning in the command cycle.
- R4: A full-row burst (`cfg_len`=7) increments the column by one per beat and wraps from 2^COL_W-1 to 0. It never ends by itself.
- R5: A read or write command issued during a burst starts a fresh burst of the full programmed length from the new column, in that same cycle.
- R6: Every read beat sets `rd_valid` exactly 2 clocks later when `cfg_cl3`=0, and exactly 3 clocks later when `cfg_cl3`=1. Read beats on back-to-back clocks give back-to-back valid cycles.
- R7: `rd_oe` equals `rd_valid` except in cycles where `dqm` was high two clocks earlier; in those cycles `rd_oe` is low.
- R8: `wr_en` is high in a write beat cycle only when `dqm` is low in that same cycle.
- R9: `cmd_stop` with no new command ends the burst. Neither that cycle nor any later cycle carries a beat, while beats already issued keep their effect.
- R10: While `rst_n` is low, and before any command has been given, `beat_act`, `wr_en`, `rd_valid` and `rd_oe` are low.
- R11: If `cmd_rd` and `cmd_wr` are both high, the command is treated as a write. A full-row burst ignores `cfg_ilv` and always runs in linear order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_len | input | 3 | Burst length code |
| cfg_ilv | input | 1 | 1 selects interleaved order |
| cfg_cl3 | input | 1 | 1 selects read latency 3, 0 selects 2 |
| cmd_rd | input | 1 | Read column command strobe |
| cmd_wr | input | 1 | Write column command strobe |
| cmd_col | input | COL_W | Start column of the command |
| cmd_stop | input | 1 | Burst stop strobe |
| dqm | input | 1 | Data mask |
| beat_act | output | 1 | A data beat is addressed this cycle |
| beat_wr | output | 1 | The current beat is a write |
| beat_col | output | COL_W | Column of the current beat |
| wr_en | output | 1 | Write the current beat |
| rd_valid | output | 1 | Read data is due on this cycle |
| rd_oe | output | 1 | Drive read data this cycle |

## Verification
The corner cases are the wrap points. A start offset near the top of a window shows whether a sequencer carries into the upper column bits instead of wrapping. An interleaved start other than zero separates XOR from addition. A full-row burst started three columns below the top must come back to column 0 and not stop at the burst count. Interrupts arrive mid-burst and must restart the count: a design that resumed the old count would end the new burst early. Stops during writes must drop the stop-cycle beat. Masks held for a single cycle during reads and writes catch a one-clock error in either mask latency. Read latency changes between runs catch a valid flag taken from the wrong stage.

// File: rtl/sdr_colseq.sv
module sdr_colseq #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cfg_len,
  input  logic             cfg_ilv,
  input  logic             cfg_cl3,
  input  logic             cmd_rd,
  input  logic             cmd_wr,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             cmd_stop,
  input  logic             dqm,
  output logic             beat_act,
  output logic             beat_wr,
  output logic [COL_W-1:0] beat_col,
  output logic             wr_en,
  output logic             rd_valid,
  output logic             rd_oe
);

  localparam int RD_DEPTH = 3;
  localparam int MASK_LAT = 2;
  localparam logic [2:0] LEN_ROW = 3'd7;

  function automatic logic [COL_W-1:0] len_mask(input logic [2:0] code);
    logic [COL_W-1:0] m;
    case (code)
      3'd1:    m = COL_W'(1);
      3'd2:    m = COL_W'(3);
      3'd3:    m = COL_W'(7);
      LEN_ROW: m = '1;
      default: m = '0;
    endcase
    return m;
  endfunction

  logic             busy, b_wr, b_ilv, b_row;
  logic [COL_W-1:0] b_base, b_idx, b_mask;
  logic [RD_DEPTH-1:0] rd_pipe;
  logic [MASK_LAT-1:0] dqm_pipe;

  wire             go       = cmd_rd | cmd_wr;
  wire [COL_W-1:0] new_mask = len_mask(cfg_len);
  wire [COL_W-1:0] walk     = b_ilv ? (b_base ^ b_idx) : (b_base + b_idx);
  wire             last     = ~b_row & (b_idx == b_mask);

  assign beat_act = go | (busy & ~cmd_stop);
  assign beat_wr  = go ? cmd_wr : b_wr;
  assign beat_col = go ? cmd_col : ((b_base & ~b_mask) | (walk & b_mask));
  assign wr_en    = beat_act & beat_wr & ~dqm;
  assign rd_valid = cfg_cl3 ? rd_pipe[RD_DEPTH-1] : rd_pipe[RD_DEPTH-2];
  assign rd_oe    = rd_valid & ~dqm_pipe[MASK_LAT-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      b_wr   <= 1'b0;
      b_ilv  <= 1'b0;
      b_row  <= 1'b0;
      b_base <= '0;
      b_idx  <= '0;
      b_mask <= '0;
    end else if (go) begin
      busy   <= (new_mask != '0);
      b_wr   <= cmd_wr;
      b_ilv  <= cfg_ilv & (cfg_len != LEN_ROW);
      b_row  <= (cfg_len == LEN_ROW);
      b_base <= cmd_col;
      b_idx  <= COL_W'(1);
      b_mask <= new_mask;
    end else if (busy) begin
      if (cmd_stop | last) busy <= 1'b0;
      else                 b_idx <= b_idx + COL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pipe  <= '0;
      dqm_pipe <= '0;
    end else begin
      rd_pipe  <= {rd_pipe[RD_DEPTH-2:0], beat_act & ~beat_wr};
      dqm_pipe <= {dqm_pipe[MASK_LAT-2:0], dqm};
    end
  end

endmodule

// File: rtl/sdr_colseq_chk.sv
module sdr_colseq_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cfg_len,
  input logic             cfg_ilv,
  input logic             cfg_cl3,
  input logic             cmd_rd,
  input logic             cmd_wr,
  input logic [COL_W-1:0] cmd_col,
  input logic             cmd_stop,
  input logic             dqm,
  input logic             beat_act,
  input logic             beat_wr,
  input logic [COL_W-1:0] beat_col,
  input logic             wr_en,
  input logic             rd_valid,
  input logic             rd_oe
);

  wire idle_cmd = !cmd_rd && !cmd_wr;

  a_r1_window: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_len == 3'd2 && !cfg_ilv && idle_cmd && beat_act && $past(beat_act))
    |-> beat_col[COL_W-1:2] == $past(beat_col[COL_W-1:2]));

  a_r3_single: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_len) == 3'd0 && $past(cmd_rd || cmd_wr) && idle_cmd) |-> !beat_act);

  a_r4_row_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_len == 3'd7 && $past(cfg_len) == 3'd7 && $past(beat_act) && !cmd_stop) |-> beat_act);

  a_r6_lat2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd && !cmd_wr && !cfg_cl3) |-> ##2 rd_valid);

  a_r6_lat3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd && !cmd_wr && cfg_cl3) |-> ##3 rd_valid);

  a_r7_oe_mask: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> !$past(dqm, 2));

  a_r9_stop_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stop && idle_cmd) |-> !beat_act);

  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_act && idle_cmd) |-> $past(beat_act));

  a_r11_wr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> (beat_wr && beat_act && beat_col == cmd_col));

endmodule

bind sdr_colseq sdr_colseq_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_ilv(cfg_ilv), .cfg_cl3(cfg_cl3),
  .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_col(cmd_col), .cmd_stop(cmd_stop), .dqm(dqm),
  .beat_act(beat_act), .beat_wr(beat_wr), .beat_col(beat_col), .wr_en(wr_en),
  .rd_valid(rd_valid), .rd_oe(rd_oe)
);

// File: tb/sdr_colseq_bench.sv
module sdr_colseq_bench;
  localparam int COL_W = 10;
  localparam int NCOL  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       cfg_len = 3'd0;
  logic             cfg_ilv = 1'b0;
  logic             cfg_cl3 = 1'b0;
  logic             cmd_rd = 1'b0, cmd_wr = 1'b0, cmd_stop = 1'b0, dqm = 1'b0;
  logic [COL_W-1:0] cmd_col = '0;
  logic             beat_act, beat_wr, wr_en, rd_valid, rd_oe;
  logic [COL_W-1:0] beat_col;

  sdr_colseq #(.COL_W(COL_W)) u_sdr_colseq (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_ilv(cfg_ilv), .cfg_cl3(cfg_cl3),
    .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_col(cmd_col), .cmd_stop(cmd_stop), .dqm(dqm),
    .beat_act(beat_act), .beat_wr(beat_wr), .beat_col(beat_col), .wr_en(wr_en),
    .rd_valid(rd_valid), .rd_oe(rd_oe)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int m_base, m_idx, m_len, m_busy, m_wr, m_ilv;
  bit hr[4];
  bit hd[3];

  function automatic int len_of(input logic [2:0] c);
    case (c)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int col_at(input int base, input int idx, input int len, input int ilv);
    int lo;
    if (len == 0) return (base + idx) % NCOL;
    lo = base % len;
    if (ilv != 0) return base - lo + (lo ^ idx);
    return base - lo + ((lo + idx) % len);
  endfunction

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic model_clear();
    m_busy = 0; m_idx = 0; m_base = 0; m_len = 1; m_wr = 0; m_ilv = 0;
    foreach (hr[i]) hr[i] = 0;
    foreach (hd[i]) hd[i] = 0;
  endtask

  task automatic cyc(input bit rd, input bit wr, input int col, input bit stp, input bit dq);
    bit go, e_act, e_wr, e_rv;
    int e_col, clen;
    string ctag;
    @(negedge clk);
    cmd_rd = rd; cmd_wr = wr; cmd_col = col[COL_W-1:0]; cmd_stop = stp; dqm = dq;
    #5;
    go    = rd | wr;
    e_act = go || (m_busy != 0 && !stp);
    e_wr  = wr ? 1'b1 : (rd ? 1'b0 : (m_wr != 0));
    e_col = go ? col : col_at(m_base, m_idx, m_len, m_ilv);
    e_rv  = cfg_cl3 ? hr[3] : hr[2];
    ctag  = (m_len == 0) ? "R4" : (m_ilv != 0 ? "R2" : "R1");
    chk(go ? "R5" : "R3", "beat_act", beat_act, e_act);
    if (e_act) begin
      chk(go ? "R11" : ctag, "beat_col", beat_col, e_col);
      chk("R11", "beat_wr", beat_wr, e_wr);
    end
    chk("R8", "wr_en", wr_en, e_act && e_wr && !dq);
    chk("R6", "rd_valid", rd_valid, e_rv);
    chk("R7", "rd_oe", rd_oe, e_rv && !hd[2]);
    // advance the model to the next clock
    hr[3] = hr[2]; hr[2] = hr[1]; hr[1] = e_act && !e_wr;
    hd[2] = hd[1]; hd[1] = dq;
    if (go) begin
      clen   = len_of(cfg_len);
      m_base = col; m_idx = 1; m_len = clen; m_wr = wr;
      m_ilv  = (clen == 0) ? 0 : cfg_ilv;
      m_busy = (clen != 1);
    end else if (m_busy != 0) begin
      if (stp || (m_len != 0 && m_idx == m_len - 1)) m_busy = 0;
      else m_idx++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic setcfg(input logic [2:0] l, input bit il, input bit c3);
    @(negedge clk);
    cfg_len = l; cfg_ilv = il; cfg_cl3 = c3;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    model_clear();
    // R10: outputs quiet in reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #5;
      chk("R10", "beat_act", beat_act, 0);
      chk("R10", "wr_en", wr_en, 0);
      chk("R10", "rd_valid", rd_valid, 0);
      chk("R10", "rd_oe", rd_oe, 0);
    end
    @(negedge clk); rst_n = 1'b1;
    idle(3);

    // R1: linear length 4 from offset 2
    setcfg(3'd2, 0, 0);
    cyc(1, 0, 10, 0, 0); idle(6);
    // R2: interleaved length 8 from 0x12
    setcfg(3'd3, 1, 0);
    cyc(1, 0, 'h12, 0, 0); idle(10);
    // R3, R8: lengths 1 and 2, writes with a one-cycle mask
    setcfg(3'd0, 0, 0);
    cyc(0, 1, 5, 0, 0); cyc(0, 1, 6, 0, 1); idle(3);
    setcfg(3'd1, 0, 0);
    cyc(0, 1, 7, 0, 0); cyc(0, 0, 0, 0, 1); idle(3);
    // R6, R7: latency 3, mask during reads, back-to-back reads
    setcfg(3'd2, 0, 1);
    cyc(1, 0, 3, 0, 0); cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0);
    cyc(1, 0, 20, 0, 0); cyc(1, 0, 40, 0, 1); idle(8);
    // R4, R11: full row from near the top, interleave flag ignored
    setcfg(3'd7, 1, 0);
    cyc(0, 1, NCOL - 3, 0, 0); idle(8); cyc(0, 0, 0, 1, 0); idle(4);
    // R5: interrupts mid-burst
    setcfg(3'd3, 0, 0);
    cyc(1, 0, 4, 0, 0); idle(2); cyc(1, 0, 'h31, 0, 0); idle(3);
    cyc(0, 1, 'h45, 0, 1); idle(9);
    // R9: stop during a write and during a read
    cyc(0, 1, 8, 0, 0); idle(2); cyc(0, 0, 0, 1, 0); idle(4);
    cyc(1, 0, 16, 0, 0); idle(3); cyc(0, 0, 0, 1, 0); idle(5);
    // R11: both strobes at once
    cyc(1, 1, 24, 0, 0); idle(9);

    for (int seg = 0; seg < 40; seg++) begin
      int lsel = $urandom % 6;
      setcfg(lsel == 4 ? 3'd7 : (lsel == 5 ? 3'd5 : 3'(lsel)), 1'($urandom), 1'($urandom));
      for (int k = 0; k < 60; k++) begin
        int r = $urandom % 10;
        cyc(r == 0 || r == 9, r == 1 || r == 9, int'($urandom % NCOL), r == 2, 1'($urandom % 3 == 0));
      end
      cyc(0, 0, 0, 1, 0); idle(4);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule